// File: doc/BRIEF.md
# Doorbell Interrupt Unit

This block keeps a bank of 32 doorbell flags for each of several CPUs (four by default) and turns them into two summary interrupt lines per CPU. Any agent raises doorbells with one encoded trigger word. The word names a doorbell number and carries a bitmap of the CPUs that should receive it. Triggers arrive either as a register write into the global space or through a dedicated inbound message port. The message port takes the data word of a message-signalled write unchanged.

Each CPU owns a pending (cause) register and an enable (mask) register in its banked register space. Flags 0 to 7 form the inter-processor group and feed one summary line. Flags 16 to 31 form the message group and feed the other. Flags 8 to 15 latch but feed neither line. Software acknowledges pending flags by writing zeros over them. Ones in the written word keep the corresponding flags as they were, so a handler can clear exactly the flags it has read without racing new arrivals.

Top module: `db_unit`

## Requirements
- R1: After reset, every cause and mask register of every CPU reads zero and all summary lines are low.
- R2: A register write to global offset 0x4, or a valid word on the message port, sets cause bit N (N = word bits [4:0]) in CPU i for every i whose bitmap bit (8 + i) is one. No other cause bit changes.
- R3: The word 0xF00 | (16 + k), for k from 0 to 15, sets cause bit 16 + k in all four CPUs.
- R4: A cause bit latches when its doorbell is triggered, whether or not its mask bit is set.
- R5: A write to per-CPU offset 0x8 of the selected CPU clears each cause bit written as 0 and keeps each bit written as 1. The other CPUs are unaffected.
- R6: Per-CPU offset 0x8 reads the cause register and offset 0xC reads the mask register. A write to offset 0xC replaces that CPU's mask and no other CPU's mask.
- R7: The inter-processor line of CPU i is the OR of cause & mask over bits 7..0. The message line is the OR of cause & mask over bits 31..16. Bits 15..8 drive neither line. The lines follow the registers in the same cycle.
- R8: If a trigger and a cause clear hit the same bit in the same cycle, the bit ends up set.
- R9: A register-space trigger and a message-port trigger in the same cycle both take effect.
- R10: A trigger with an all-zero CPU bitmap changes nothing. Writes to unassigned offsets in either space also change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_global | input | 1 | 1: the write goes to the global space; 0: it goes to the banked per-CPU space |
| reg_cpu | input | CPU_W | CPU whose banked registers a per-CPU write addresses |
| reg_addr | input | ADDR_W | Byte offset of the write |
| reg_wdata | input | 32 | Write data |
| msg_valid | input | 1 | Inbound message-signalled write present |
| msg_data | input | 32 | Data word of the inbound message write, in trigger format |
| rd_cpu | input | CPU_W | CPU whose banked registers are read |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | 32 | Combinational read data; zero at unassigned offsets |
| irq_ipi | output | NUM_CPU | Inter-processor summary line per CPU |
| irq_msg | output | NUM_CPU | Message summary line per CPU |

## Verification
The hardest case to reach is a trigger and an acknowledge landing on the same cause bit in the same clock. A single register port cannot carry both in one write. The stimulus therefore pairs a message-port trigger with a banked cause write of all zeros in one cycle, and then reads the register back. The same two-port pairing makes two triggers arrive together. Doorbells 8 to 15 are raised with their masks fully open, to show that the summary lines stay low while the cause bits still read as set.

// File: rtl/db_pkg.sv
`timescale 1ns/1ps
package db_pkg;
    localparam int DB_NUM       = 32;
    localparam int DB_IDX_W     = $clog2(DB_NUM);
    localparam int TRIG_MAP_LSB = 8;
    localparam int IPI_LO       = 0;
    localparam int IPI_HI       = 7;
    localparam int MSG_LO       = 16;
    localparam int MSG_HI       = 31;
    localparam int SRC_N        = 2;

    localparam logic [7:0] OFS_TRIGGER = 8'h04;
    localparam logic [7:0] OFS_CAUSE   = 8'h08;
    localparam logic [7:0] OFS_MASK    = 8'h0C;

    typedef logic [DB_NUM-1:0] db_vec_t;

    typedef struct packed {
        db_vec_t cause;
        db_vec_t mask;
    } bank_t;

    function automatic db_vec_t group_sel(input int lo, input int hi);
        db_vec_t sel;
        sel = '0;
        for (int i = 0; i < DB_NUM; i++) begin
            if (i >= lo && i <= hi) sel[i] = 1'b1;
        end
        return sel;
    endfunction
endpackage

// File: rtl/db_trig_decode.sv
`timescale 1ns/1ps
module db_trig_decode
    import db_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                           valid,
    input  db_vec_t                        data,
    output logic [NUM_CPU-1:0][DB_NUM-1:0] set_o
);
    localparam int MAP_HI = TRIG_MAP_LSB + NUM_CPU;

    logic [DB_IDX_W-1:0] num;
    logic                unused_bits;

    assign num         = data[DB_IDX_W-1:0];
    assign unused_bits = ^{data[TRIG_MAP_LSB-1:DB_IDX_W], data[DB_NUM-1:MAP_HI]};

    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            set_o[c] = (valid && data[TRIG_MAP_LSB+c]) ? (DB_NUM'(1) << num) : '0;
        end
    end
endmodule

// File: rtl/db_cpu_bank.sv
`timescale 1ns/1ps
module db_cpu_bank
    import db_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  db_vec_t set_i,
    input  logic    clr_we,
    input  db_vec_t clr_data,
    input  logic    mask_we,
    input  db_vec_t mask_data,
    output db_vec_t cause_o,
    output db_vec_t mask_o
);
    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (clr_we) begin
            bank_d.cause = bank_q.cause & clr_data;
        end
        bank_d.cause = bank_d.cause | set_i;
        if (mask_we) begin
            bank_d.mask = mask_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign cause_o = bank_q.cause;
    assign mask_o  = bank_q.mask;

    AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((bank_q.cause & $past(set_i)) == $past(set_i))); // R4

    AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && (|(set_i & ~clr_data))) |=>
        ((bank_q.cause & $past(set_i)) == $past(set_i))); // R8

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bank_q.cause & ~$past(bank_q.cause) & ~$past(set_i)) == '0)); // R2

    AST_CLEAR_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((bank_q.cause & $past(clr_data & bank_q.cause))
                    == $past(clr_data & bank_q.cause))); // R5

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(bank_q.mask)); // R6
endmodule

// File: rtl/db_summary.sv
`timescale 1ns/1ps
module db_summary
    import db_pkg::*;
(
    input  db_vec_t cause,
    input  db_vec_t mask,
    output logic    ipi,
    output logic    msg
);
    localparam db_vec_t IPI_SEL = group_sel(IPI_LO, IPI_HI);
    localparam db_vec_t MSG_SEL = group_sel(MSG_LO, MSG_HI);

    db_vec_t hit;

    always_comb begin
        hit = cause & mask;
        ipi = |(hit & IPI_SEL);
        msg = |(hit & MSG_SEL);
    end
endmodule

// File: rtl/db_unit.sv
`timescale 1ns/1ps
module db_unit
    import db_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 8,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_global,
    input  logic [CPU_W-1:0]   reg_cpu,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic               msg_valid,
    input  logic [31:0]        msg_data,
    input  logic [CPU_W-1:0]   rd_cpu,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [31:0]        rd_data,
    output logic [NUM_CPU-1:0] irq_ipi,
    output logic [NUM_CPU-1:0] irq_msg
);
    localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(OFS_TRIGGER);
    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);

    logic [SRC_N-1:0]                          src_valid;
    logic [SRC_N-1:0][DB_NUM-1:0]              src_data;
    logic [SRC_N-1:0][NUM_CPU-1:0][DB_NUM-1:0] set_src;
    logic [NUM_CPU-1:0][DB_NUM-1:0]            set_all;
    logic [NUM_CPU-1:0][DB_NUM-1:0]            cause_all;
    logic [NUM_CPU-1:0][DB_NUM-1:0]            mask_all;

    assign src_valid[0] = reg_wr && reg_global && (reg_addr == A_TRIG);
    assign src_data[0]  = reg_wdata;
    assign src_valid[1] = msg_valid;
    assign src_data[1]  = msg_data;

    for (genvar s = 0; s < SRC_N; s++) begin : g_src
        db_trig_decode #(.NUM_CPU(NUM_CPU)) i_dec (
            .valid (src_valid[s]),
            .data  (src_data[s]),
            .set_o (set_src[s])
        );
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
            AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(set_src[s][c])); // R2
        end
    end

    always_comb begin
        set_all = '0;
        for (int s = 0; s < SRC_N; s++) begin
            set_all = set_all | set_src[s];
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic sel_cpu;
        assign sel_cpu = reg_wr && !reg_global && (reg_cpu == CPU_W'(c));

        db_cpu_bank i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_all[c]),
            .clr_we    (sel_cpu && (reg_addr == A_CAUSE)),
            .clr_data  (reg_wdata),
            .mask_we   (sel_cpu && (reg_addr == A_MASK)),
            .mask_data (reg_wdata),
            .cause_o   (cause_all[c]),
            .mask_o    (mask_all[c])
        );

        db_summary i_sum (
            .cause (cause_all[c]),
            .mask  (mask_all[c]),
            .ipi   (irq_ipi[c]),
            .msg   (irq_msg[c])
        );

        AST_IPI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_all[c][IPI_HI:IPI_LO] == '0) |-> !irq_ipi[c]); // R7
        AST_MSG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            (cause_all[c][MSG_HI:MSG_LO] == '0) |-> !irq_msg[c]); // R7
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CAUSE)     rd_data = cause_all[rd_cpu];
        else if (rd_addr == A_MASK) rd_data = mask_all[rd_cpu];
    end
endmodule

// File: tb/test_db_unit.sv
`timescale 1ns/1ps
module test_db_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_global = 1'b0;
    logic [1:0]  reg_cpu = '0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        msg_valid = 1'b0;
    logic [31:0] msg_data = '0;
    logic [1:0]  rd_cpu = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  irq_ipi, irq_msg;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_cause [4];
    logic [31:0] m_mask  [4];
    logic [7:0]  exp_q [$];
    string       req_q [$];

    always #10 clk = ~clk;

    db_unit i_db_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_global(reg_global),
        .reg_cpu(reg_cpu), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .msg_valid(msg_valid), .msg_data(msg_data), .rd_cpu(rd_cpu),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_ipi(irq_ipi), .irq_msg(irq_msg)
    );

    function automatic logic [7:0] model_irq();
        logic [7:0] r;
        for (int c = 0; c < 4; c++) begin
            r[c]     = |(m_cause[c][7:0]   & m_mask[c][7:0]);
            r[4 + c] = |(m_cause[c][31:16] & m_mask[c][31:16]);
        end
        return r;
    endfunction

    task automatic model_trigger(input logic [31:0] w, inout logic [31:0] s [4]);
        for (int c = 0; c < 4; c++) begin
            if (w[8 + c]) s[c][w[4:0]] = 1'b1;
        end
    endtask

    // Driver: applies one cycle of stimulus, updates the model, queues expected lines
    task automatic op(input logic wr, input logic glob, input int cpu, input logic [7:0] addr,
                      input logic [31:0] wd, input logic mv, input logic [31:0] md,
                      input string req);
        logic [31:0] s [4];
        @(negedge clk);
        reg_wr = wr; reg_global = glob; reg_cpu = 2'(cpu); reg_addr = addr;
        reg_wdata = wd; msg_valid = mv; msg_data = md;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; msg_valid = 1'b0;
        for (int c = 0; c < 4; c++) s[c] = '0;
        if (wr && glob && addr == 8'h04) model_trigger(wd, s);
        if (mv) model_trigger(md, s);
        if (wr && !glob && addr == 8'h08) m_cause[cpu] = m_cause[cpu] & wd;
        if (wr && !glob && addr == 8'h0C) m_mask[cpu] = wd;
        for (int c = 0; c < 4; c++) m_cause[c] = m_cause[c] | s[c];
        exp_q.push_back(model_irq());
        req_q.push_back(req);
    endtask

    // Monitor: compares summary lines half a cycle after each driven edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string      r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            checks++;
            if ({irq_msg, irq_ipi} !== e) begin
                fails++;
                $display("FAIL %s summary lines: got %h expected %h", r, {irq_msg, irq_ipi}, e);
            end
        end
    end

    task automatic check_regs(input string req);
        @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            rd_cpu = 2'(c);
            rd_addr = 8'h08;
            #1;
            checks++;
            if (rd_data !== m_cause[c]) begin
                fails++;
                $display("FAIL %s cause cpu%0d: got %h expected %h", req, c, rd_data, m_cause[c]);
            end
            rd_addr = 8'h0C;
            #1;
            checks++;
            if (rd_data !== m_mask[c]) begin
                fails++;
                $display("FAIL %s mask cpu%0d: got %h expected %h", req, c, rd_data, m_mask[c]);
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin m_cause[c] = '0; m_mask[c] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        op(0, 0, 0, 8'h00, 0, 0, 0, "R1");
        check_regs("R1");
        // R6: per-CPU masks
        op(1, 0, 0, 8'h0C, 32'h0000_00FF, 0, 0, "R6");
        op(1, 0, 1, 8'h0C, 32'hFFFF_0000, 0, 0, "R6");
        op(1, 0, 2, 8'h0C, 32'hFFFF_00FF, 0, 0, "R6");
        check_regs("R6");
        // R2 R4 R7: doorbell 5 to CPUs 0 and 1; CPU1 masks it out
        op(1, 1, 0, 8'h04, 32'h0000_0305, 0, 0, "R2");
        check_regs("R4");
        // R3: one message doorbell, then the whole message range
        op(0, 0, 0, 8'h00, 0, 1, 32'h0000_0F13, "R3");
        check_regs("R3");
        for (int k = 0; k < 16; k++) op(0, 0, 0, 8'h00, 0, 1, 32'h0F00 | (16 + k), "R3");
        check_regs("R3");
        // R7: doorbell 10 with mask fully open drives no line
        op(1, 0, 3, 8'h0C, 32'hFFFF_FFFF, 0, 0, "R7");
        op(1, 0, 3, 8'h08, 32'h0000_0000, 0, 0, "R7");
        op(1, 1, 0, 8'h04, 32'h0000_080A, 0, 0, "R7");
        check_regs("R7");
        // R5: clear doorbell 5 of CPU0 only
        op(1, 0, 0, 8'h08, ~32'h0000_0020, 0, 0, "R5");
        check_regs("R5");
        // R8: clear-all and trigger of doorbell 2 on CPU0 in one cycle
        op(1, 0, 0, 8'h08, 32'h0000_0000, 1, 32'h0000_0102, "R8");
        check_regs("R8");
        // R9: two triggers to CPU3 in one cycle
        op(1, 1, 0, 8'h04, 32'h0000_0801, 1, 32'h0000_0806, "R9");
        check_regs("R9");
        // R10: empty bitmap, unassigned offsets
        op(1, 1, 0, 8'h04, 32'h0000_0007, 0, 0, "R10");
        op(1, 0, 2, 8'h10, 32'h0000_0000, 0, 0, "R10");
        op(1, 1, 0, 8'h08, 32'h0000_0000, 0, 0, "R10");
        op(1, 1, 0, 8'h0C, 32'h0000_0000, 0, 0, "R10");
        check_regs("R10");
        repeat (3) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule